// File: doc/BRIEF.md
# Counted Multi-Stage Trigger Sequencer

This block turns the single-bit results of a bank of pattern match units into one trigger event. It walks through an ordered list of stages. Each stage names a subset of the match bits and a way to combine them into a term. It then waits until that term has been true a programmed number of times. Only the counter of the stage in progress advances. Once the final programmed stage reaches its count, the block emits a one-cycle trigger pulse and latches a done flag.

Software arms the block with `arm`. Removing `arm` returns every stage counter and the stage pointer to their idle values. The `chain_en` input gates all counting. Several sequencers can therefore be cascaded by feeding the `done` output of one into `chain_en` of the next. The final stage can be any of the implemented stages, so shorter sequences need no dummy stages.

Top module: `trig_sequencer`

## Requirements
- R1: While reset is low, or at the first clock edge after `arm` is sampled low, `stage` is 0 and `done` and `trig` are 0. All stage counters restart from zero, so a re-armed run needs the full count of every stage again.
- R2: With mode bit k = 0 (any-of), the stage-k term is true on a clock when at least one match bit selected by mask `stage_sel[k*8 +: 8]` is high. Unselected match bits have no effect. An all-zero mask is never true.
- R3: With mode bit k = 1 (all-of), the stage-k term is true only when every selected match bit is high and the mask is not all zero.
- R4: Each clock edge on which the current stage's term is true counts one occurrence, whether or not the occurrences are consecutive. The stage is left at the edge that records occurrence N, where N is `stage_cnt[k*12 +: 12]` (counts up to 4095, e.g. 1024).
- R5: A programmed count of 0 behaves like a count of 1: the stage is left on its first occurrence.
- R6: Stages complete strictly in order from stage 0 upward. A term belonging to a stage not yet reached is not counted, even if it is true.
- R7: `last_stage` selects the final stage (0 to 3). Completing any earlier stage only increments `stage` by one.
- R8: `trig` is high for exactly one cycle, right after the edge that records the final stage's last occurrence. `done` rises on the same cycle.
- R9: Once `done` is high and `arm` stays high, `done` stays high, `stage` holds, and further matches produce no new `trig`.
- R10: While `chain_en` is low, no occurrence is counted and `stage` holds.
- R11: `stage` never moves by more than one step upward per clock while armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | High to run; low clears the sequence |
| chain_en | input | 1 | Counting enable, e.g. `done` of a preceding sequencer |
| match | input | 8 | One bit per match unit |
| stage_sel | input | 32 | Per-stage match mask, stage k at bits k*8 +: 8 |
| stage_mode | input | 4 | Per-stage combine mode, 0 = any-of, 1 = all-of |
| stage_cnt | input | 48 | Per-stage occurrence count, stage k at bits k*12 +: 12 |
| last_stage | input | 2 | Index of the final stage |
| trig | output | 1 | One-cycle trigger pulse |
| stage | output | 2 | Index of the stage in progress |
| done | output | 1 | Sequence complete, held until disarmed |

## Verification
On every cycle, the assertions check the following. The pointer moves at most one step. The trigger is a lone pulse that coincides with the rise of `done`. Disarming clears the state. `done` is held. A low `chain_en` freezes the pointer. Each counter steps by one per counted occurrence. The bench scenarios are needed to show the things that depend on the configuration: the exact edge on which each stage ends for a given count, including zero and 1024; the treatment of masks under both combine modes; the refusal to count a later stage's term early; and the full restart after a mid-run disarm.

// File: rtl/trigseq_pkg.sv
package trigseq_pkg;

   // How a stage folds its selected match bits into one term.
   typedef enum logic {
      TERM_ANY = 1'b0,
      TERM_ALL = 1'b1
   } term_mode_e;

   // Registered sequence flags.
   typedef struct packed {
      logic done;
      logic trig;
   } seq_flags_t;

endpackage

// File: rtl/seq_term_eval.sv
module seq_term_eval
   import trigseq_pkg::*;
#(
   parameter int NUM_MATCH  = 8,
   parameter int NUM_STAGES = 4
) (
   input  logic [NUM_MATCH-1:0]            match_i,
   input  logic [NUM_STAGES*NUM_MATCH-1:0] sel_i,
   input  logic [NUM_STAGES-1:0]           mode_i,
   output logic [NUM_STAGES-1:0]           term_o
);

   for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
      logic [NUM_MATCH-1:0] mask;
      logic [NUM_MATCH-1:0] hit_bits;
      logic                 mask_any;

      assign mask     = sel_i[k*NUM_MATCH +: NUM_MATCH];
      assign hit_bits = match_i & mask;
      assign mask_any = |mask;

      always_comb begin
         if (term_mode_e'(mode_i[k]) == TERM_ALL)
            term_o[k] = mask_any && (hit_bits == mask);
         else
            term_o[k] = |hit_bits;
      end
   end

endmodule

// File: rtl/seq_stage_ctr.sv
module seq_stage_ctr #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   input  logic [CNT_W-1:0] target_i,
   output logic             reach_o
);

   localparam int SUM_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [SUM_W-1:0] next_cnt;
   logic [SUM_W-1:0] eff_target;

   assign next_cnt   = {1'b0, cnt_q} + SUM_W'(1);
   assign eff_target = (target_i == '0) ? SUM_W'(1) : {1'b0, target_i};
   assign reach_o    = inc_i && (next_cnt >= eff_target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_i)
         cnt_q <= '0;
      else if (inc_i)
         cnt_q <= next_cnt[CNT_W-1:0];
   end

   // R4: every counted occurrence adds exactly one
   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !clr_i && (cnt_q != '1)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

   // R1: a clear empties the counter
   p_count_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
   import trigseq_pkg::*;
#(
   parameter int NUM_STAGES = 4,
   parameter int STG_W      = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  arm_i,
   input  logic                  chain_en_i,
   input  logic [STG_W-1:0]      last_i,
   input  logic [NUM_STAGES-1:0] reach_i,
   output logic [STG_W-1:0]      stage_o,
   output logic                  done_o,
   output logic                  trig_o,
   output logic                  active_o
);

   localparam logic [STG_W-1:0] TOP_IDX = STG_W'(NUM_STAGES - 1);

   logic [STG_W-1:0] stage_q;
   seq_flags_t       flags_q;
   logic [STG_W-1:0] last_eff;
   logic             reach_cur;

   assign last_eff  = (last_i > TOP_IDX) ? TOP_IDX : last_i;
   assign active_o  = arm_i && chain_en_i && !flags_q.done;
   assign reach_cur = reach_i[stage_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         flags_q <= '0;
      end else if (!arm_i) begin
         stage_q <= '0;
         flags_q <= '0;
      end else begin
         flags_q.trig <= 1'b0;
         if (active_o && reach_cur) begin
            if (stage_q >= last_eff) begin
               flags_q.done <= 1'b1;
               flags_q.trig <= 1'b1;
            end else begin
               stage_q <= stage_q + STG_W'(1);
            end
         end
      end
   end

   assign stage_o = stage_q;
   assign done_o  = flags_q.done;
   assign trig_o  = flags_q.trig;

   // R11: pointer moves at most one step per clock
   p_stage_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_i && $past(arm_i)) |->
         ((stage_o == $past(stage_o)) || (stage_o == $past(stage_o) + STG_W'(1))));

   // R8: trigger is a lone pulse
   p_trig_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |=> !trig_o);

   // R8: done rises together with the trigger
   p_done_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> trig_o);

   // R1: disarming clears the sequence
   p_disarm_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_i |=> ((stage_o == '0) && !done_o && !trig_o));

   // R9: done is held while armed and the pointer freezes
   p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && arm_i) |=> (done_o && $stable(stage_o) && !trig_o));

   // R10: a low chain enable freezes progress
   p_chain_pause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_i && !chain_en_i) |=> ($stable(stage_o) && !trig_o));

endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
   import trigseq_pkg::*;
#(
   parameter int NUM_MATCH  = 8,
   parameter int NUM_STAGES = 4,
   parameter int CNT_W      = 12,
   parameter int STG_W      = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            arm,
   input  logic                            chain_en,
   input  logic [NUM_MATCH-1:0]            match,
   input  logic [NUM_STAGES*NUM_MATCH-1:0] stage_sel,
   input  logic [NUM_STAGES-1:0]           stage_mode,
   input  logic [NUM_STAGES*CNT_W-1:0]     stage_cnt,
   input  logic [STG_W-1:0]                last_stage,
   output logic                            trig,
   output logic [STG_W-1:0]                stage,
   output logic                            done
);

   if (NUM_MATCH < 1)                 begin : g_bad_match $error("NUM_MATCH must be at least 1"); end
   if (NUM_STAGES < 1)                begin : g_bad_stg   $error("NUM_STAGES must be at least 1"); end
   if (CNT_W < 1)                     begin : g_bad_cnt   $error("CNT_W must be at least 1"); end
   if ((1 << STG_W) < NUM_STAGES)     begin : g_bad_sw    $error("STG_W too narrow for NUM_STAGES"); end

   logic [NUM_STAGES-1:0] term;
   logic [NUM_STAGES-1:0] inc;
   logic [NUM_STAGES-1:0] reach;
   logic                  active;

   seq_term_eval #(
      .NUM_MATCH (NUM_MATCH),
      .NUM_STAGES(NUM_STAGES)
   ) u_term (
      .match_i(match),
      .sel_i  (stage_sel),
      .mode_i (stage_mode),
      .term_o (term)
   );

   for (genvar k = 0; k < NUM_STAGES; k++) begin : g_ctr
      assign inc[k] = active && (stage == STG_W'(k)) && term[k];

      seq_stage_ctr #(
         .CNT_W(CNT_W)
      ) u_ctr (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_i   (!arm),
         .inc_i   (inc[k]),
         .target_i(stage_cnt[k*CNT_W +: CNT_W]),
         .reach_o (reach[k])
      );
   end

   seq_ctrl #(
      .NUM_STAGES(NUM_STAGES),
      .STG_W     (STG_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (arm),
      .chain_en_i(chain_en),
      .last_i    (last_stage),
      .reach_i   (reach),
      .stage_o   (stage),
      .done_o    (done),
      .trig_o    (trig),
      .active_o  (active)
   );

   // R6: at most one stage counter advances per clock
   p_one_counter_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(inc));

endmodule

// File: tb/sim_trig_sequencer.sv
module sim_trig_sequencer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0;
   logic        chain_en = 1'b0;
   logic [7:0]  match = '0;
   logic [31:0] sel = '0;
   logic [3:0]  mode = '0;
   logic [47:0] cnt = '0;
   logic [1:0]  last = '0;
   logic        trig;
   logic [1:0]  stage;
   logic        done;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   trig_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .arm(arm), .chain_en(chain_en), .match(match),
      .stage_sel(sel), .stage_mode(mode), .stage_cnt(cnt), .last_stage(last),
      .trig(trig), .stage(stage), .done(done)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic state_chk(input string req, input int e_stage, input int e_done, input int e_trig);
      chk({req, " stage"}, int'(stage), e_stage);
      chk({req, " done"},  int'(done),  e_done);
      chk({req, " trig"},  int'(trig),  e_trig);
   endtask

   task automatic disarm();
      arm = 1'b0; match = '0; tick();
   endtask

   function automatic int eff(input int c);
      return (c == 0) ? 1 : c;
   endfunction

   // Continuous-hit sweep over final stage and counts
   task automatic sweep();
      for (int lst = 0; lst < 4; lst++) begin
         for (int base = 0; base < 3; base++) begin
            int c[4];
            int tot;
            disarm();
            state_chk("R1 disarm", 0, 0, 0);
            tot = 0;
            for (int k = 0; k < 4; k++) begin
               c[k] = (base + 2 * k) % 5;
               cnt[k*12 +: 12] = 12'(c[k]);
               sel[k*8 +: 8] = 8'(1 << k);
               if (k <= lst) tot += eff(c[k]);
            end
            mode = 4'b0000; last = 2'(lst); chain_en = 1'b1;
            arm = 1'b1; match = 8'hFF;
            for (int i = 1; i <= tot + 3; i++) begin
               int es, acc;
               tick();
               es = 0; acc = 0;
               for (int k = 0; k <= lst; k++) begin
                  acc += eff(c[k]);
                  if (i >= acc && k < lst) es = k + 1;
               end
               chk("R4/R5/R7 stage", int'(stage), es);
               chk("R8/R9 done", int'(done), (i >= tot) ? 1 : 0);
               chk("R8 trig", int'(trig), (i == tot) ? 1 : 0);
            end
         end
      end
   endtask

   initial begin
      repeat (3) tick();
      state_chk("R1 reset", 0, 0, 0);
      rst_n = 1'b1;
      tick();
      state_chk("R1 after reset", 0, 0, 0);

      sweep();

      // R2: any-of with gaps and an unselected bit
      disarm();
      sel = '0; sel[7:0] = 8'h30; mode = 4'b0000; cnt = '0; cnt[11:0] = 12'd3;
      last = 2'd0; chain_en = 1'b1; arm = 1'b1;
      match = 8'h10; tick();
      match = 8'h01; tick();
      state_chk("R2 unselected bit ignored", 0, 0, 0);
      match = 8'h20; tick();
      match = 8'h00; tick();
      state_chk("R4 gap not done", 0, 0, 0);
      match = 8'h30; tick();
      state_chk("R2 any-of third hit", 0, 1, 1);
      tick();
      state_chk("R9 held after fire", 0, 1, 0);

      // R2: empty mask in any-of mode never true
      disarm();
      sel[7:0] = 8'h00; cnt[11:0] = 12'd1; arm = 1'b1; match = 8'hFF;
      repeat (3) tick();
      state_chk("R2 empty mask", 0, 0, 0);

      // R3: all-of mode
      disarm();
      sel[7:0] = 8'h06; mode = 4'b0001; cnt[11:0] = 12'd2; arm = 1'b1;
      match = 8'h02; repeat (3) tick();
      state_chk("R3 partial match", 0, 0, 0);
      match = 8'h06; tick();
      state_chk("R3 first full match", 0, 0, 0);
      tick();
      state_chk("R3 second full match", 0, 1, 1);
      disarm();
      sel[7:0] = 8'h00; arm = 1'b1; match = 8'hFF; repeat (3) tick();
      state_chk("R3 empty mask all-of", 0, 0, 0);

      // R6: strict order
      disarm();
      sel = '0; sel[7:0] = 8'h01; sel[15:8] = 8'h02; mode = 4'b0000;
      cnt = '0; cnt[11:0] = 12'd1; cnt[23:12] = 12'd2; last = 2'd1; arm = 1'b1;
      match = 8'h02; repeat (3) tick();
      state_chk("R6 later term early", 0, 0, 0);
      match = 8'h01; tick();
      state_chk("R6 stage0 done", 1, 0, 0);
      match = 8'h02; tick();
      state_chk("R6 early hits not counted", 1, 0, 0);
      tick();
      state_chk("R6 stage1 complete", 1, 1, 1);

      // R10: chain enable gates counting
      disarm();
      sel = '0; sel[7:0] = 8'h01; cnt = '0; cnt[11:0] = 12'd3; last = 2'd0;
      chain_en = 1'b0; arm = 1'b1; match = 8'h01;
      repeat (5) tick();
      state_chk("R10 paused", 0, 0, 0);
      chain_en = 1'b1; repeat (2) tick();
      state_chk("R10 resumed partial", 0, 0, 0);
      tick();
      state_chk("R10 resumed complete", 0, 1, 1);

      // R1: mid-run disarm restarts all counters
      disarm();
      sel[15:8] = 8'h01; cnt[11:0] = 12'd2; cnt[23:12] = 12'd2; last = 2'd1;
      arm = 1'b1; match = 8'h01; repeat (3) tick();
      state_chk("R1 mid-run stage", 1, 0, 0);
      arm = 1'b0; tick();
      state_chk("R1 disarm mid-run", 0, 0, 0);
      arm = 1'b1; repeat (3) tick();
      state_chk("R1 full recount", 1, 0, 0);
      tick();
      state_chk("R1 recount complete", 1, 1, 1);

      // R4: large count
      disarm();
      sel = '0; sel[7:0] = 8'h80; cnt = '0; cnt[11:0] = 12'd1024; last = 2'd0;
      arm = 1'b1; match = 8'h80;
      repeat (1023) tick();
      state_chk("R4 count 1023 of 1024", 0, 0, 0);
      tick();
      state_chk("R4 count 1024", 0, 1, 1);
      disarm();
      state_chk("R1 final disarm", 0, 0, 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule